// File: doc/BRIEF.md
# Policy-Driven Clock Enable Register Block

This block turns a set of per-policy clock masks into per-clock enable lines. Software programs one mask word per power policy, with each clock owning the same bit position in every mask. An active-policy input picks which mask drives the enable outputs. The policy engine, which copies the selected mask to the enables, can be frozen so that the masks can be rewritten. It is then restarted through a control register.

Every register except the access register is write-protected. Software first writes the access register (word address 0). The write carries a fixed password in its upper bits and sets bit 0 to one, which unlocks the block. A later password write with bit 0 cleared locks it again. Locked writes are dropped without any error. Reads are never blocked.

Word map: 0 access, 1 halt (bit 0 freezes the engine), 2 control (bit 0 GO, bit 1 GO_ATL mode, bit 2 GO_AC mode), 3 reads zero, 4 to 7 masks for policies 0 to 3.

Top module: `clkpol_regs`

## Requirements
- R1: After reset the block is locked, the engine runs, all masks read 0xFFFFFFFF, the control register reads 0, and clk_en is all ones.
- R2: A write to word 0 whose bits 31:8 equal 0x5AC3E7 loads the unlock flag from bit 0. A write to word 0 with any other value in bits 31:8 leaves the flag unchanged. Word 0 reads the flag in bit 0.
- R3: While the block is locked, writes to words 1 to 7 are dropped, and read-back shows the old values.
- R4: A password write with bit 0 clear locks the block again, and later writes to other registers are dropped.
- R5: When the block is unlocked, writing word 1 sets or clears the halt bit, and word 1 reads it back in bit 0.
- R6: A mask write is accepted only while the block is unlocked and halted. Mask writes made while the engine runs are ignored.
- R7: While the engine runs, clk_en equals the mask of the policy on pol_sel, one clock edge after pol_sel is applied.
- R8: While the engine is halted, clk_en holds its value, whatever happens to pol_sel or the masks.
- R9: An unlocked control write with bit 0 set and bit 1 or bit 2 set restarts the engine. GO reads 1 for one cycle, then clears by itself together with the halt bit. The mode bits keep the values written.
- R10: A control write with bit 0 set but bits 1 and 2 both clear is ignored. The engine stays halted and GO stays 0.
- R11: Reads return register contents whether the block is locked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for bus_addr and bus_wdata |
| bus_addr | input | 3 | Word address, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pol_sel | input | 2 | Index of the active policy |
| clk_en | output | 32 | Per-clock enable lines |

## Verification
Several faults are only visible through read-back. A stuck unlock flag shows as a mask or halt word changing when it should not, within the same write. A bad write-enable gate on the masks shows at the next mask read, or two edges after restart as an enable pattern that does not match. A restart path that never clears halt leaves clk_en frozen. A GO that does not self-clear leaves bit 0 of the control word set. Both are seen at the first read or enable check after the control write.

// File: rtl/clkpol_pkg.sv
package clkpol_pkg;
   localparam int unsigned REG_ACCESS = 0;
   localparam int unsigned REG_HALT   = 1;
   localparam int unsigned REG_CTL    = 2;
   localparam int unsigned CTL_GO     = 0;
   localparam int unsigned CTL_ATL    = 1;
   localparam int unsigned CTL_AC     = 2;

   typedef struct packed {
      logic ac;
      logic atl;
      logic go;
   } ctl_t;
endpackage

// File: rtl/clkpol_access.sv
module clkpol_access #(
   parameter int unsigned PW_W   = 24,
   parameter logic [PW_W-1:0] PASSWD = 24'h5AC3E7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_wr,
   input  logic [PW_W-1:0] acc_key,
   input  logic            acc_bit,
   output logic            wr_open
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_open <= 1'b0;
      end else if (acc_wr && (acc_key == PASSWD)) begin
         wr_open <= acc_bit;
      end
   end
endmodule

// File: rtl/clkpol_engine.sv
module clkpol_engine
   import clkpol_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_wr,
   input  logic       ctl_wr,
   input  logic [2:0] wbits,
   output logic       halt_q,
   output ctl_t       ctl_q
);
   logic go_ok;
   assign go_ok = wbits[CTL_GO] && (wbits[CTL_ATL] || wbits[CTL_AC]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         ctl_q  <= '0;
      end else begin
         if (halt_wr) begin
            halt_q <= wbits[0];
         end
         if (ctl_q.go) begin
            // restart completes: engine resumes, GO drops
            halt_q   <= 1'b0;
            ctl_q.go <= 1'b0;
         end else if (ctl_wr && go_ok) begin
            ctl_q.go  <= 1'b1;
            ctl_q.atl <= wbits[CTL_ATL];
            ctl_q.ac  <= wbits[CTL_AC];
         end
      end
   end
endmodule

// File: rtl/clkpol_mask_bank.sv
module clkpol_mask_bank #(
   parameter int unsigned NUM_POL  = 4,
   parameter int unsigned NUM_CLK  = 32,
   parameter int unsigned POL_W    = 2,
   parameter logic [NUM_CLK-1:0] RST_MASK = '1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [POL_W-1:0]           wr_idx,
   input  logic [NUM_CLK-1:0]         wr_val,
   input  logic [POL_W-1:0]           rd_idx,
   input  logic [POL_W-1:0]           pol_idx,
   output logic [NUM_CLK-1:0]         rd_mask,
   output logic [NUM_CLK-1:0]         sel_mask,
   output logic [NUM_POL*NUM_CLK-1:0] mask_flat
);
   logic [NUM_CLK-1:0] mask_q [NUM_POL];

   for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[p] <= RST_MASK;
         end else if (wr_en && (wr_idx == POL_W'(p))) begin
            mask_q[p] <= wr_val;
         end
      end
      assign mask_flat[p*NUM_CLK +: NUM_CLK] = mask_q[p];
   end

   always_comb begin
      rd_mask  = '0;
      sel_mask = '0;
      for (int p = 0; p < NUM_POL; p++) begin
         if (rd_idx == POL_W'(p))  rd_mask  = mask_q[p];
         if (pol_idx == POL_W'(p)) sel_mask = mask_q[p];
      end
   end
endmodule

// File: rtl/clkpol_regs.sv
module clkpol_regs
   import clkpol_pkg::*;
#(
   parameter int unsigned NUM_POL = 4,
   parameter int unsigned NUM_CLK = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned PW_W    = 24,
   parameter logic [PW_W-1:0] PASSWD = 24'h5AC3E7,
   parameter logic [NUM_CLK-1:0] RST_MASK = '1,
   localparam int unsigned POL_W = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [POL_W-1:0]  pol_sel,
   output logic [NUM_CLK-1:0] clk_en
);
   localparam logic [ADDR_W-1:0] NPOL_A = ADDR_W'(NUM_POL);

   if (NUM_CLK > DATA_W) begin : g_chk_clk
      $error("NUM_CLK must fit in DATA_W");
   end
   if (PW_W + 1 > DATA_W) begin : g_chk_pw
      $error("password field overlaps unlock bit");
   end
   if (NUM_POL > (1 << (ADDR_W - 1))) begin : g_chk_pol
      $error("mask window too small for NUM_POL");
   end
   if (ADDR_W - 1 < POL_W) begin : g_chk_aw
      $error("ADDR_W too narrow for policy index");
   end

   logic                       wr_open;
   logic                       halt_q;
   ctl_t                       ctl_q;
   logic                       is_mask;
   logic [POL_W-1:0]           m_idx;
   logic [NUM_CLK-1:0]         rd_mask;
   logic [NUM_CLK-1:0]         sel_mask;
   logic [NUM_POL*NUM_CLK-1:0] mask_flat;
   logic                       acc_wr, halt_wr, ctl_wr, mask_wr;

   assign is_mask = bus_addr[ADDR_W-1] &&
                    ({1'b0, bus_addr[ADDR_W-2:0]} < NPOL_A);
   assign m_idx   = POL_W'(bus_addr[ADDR_W-2:0]);

   assign acc_wr  = bus_wr && (bus_addr == ADDR_W'(REG_ACCESS));
   assign halt_wr = bus_wr && wr_open && (bus_addr == ADDR_W'(REG_HALT));
   assign ctl_wr  = bus_wr && wr_open && (bus_addr == ADDR_W'(REG_CTL));
   assign mask_wr = bus_wr && wr_open && halt_q && is_mask;

   clkpol_access #(.PW_W(PW_W), .PASSWD(PASSWD)) u_access (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_wr  (acc_wr),
      .acc_key (bus_wdata[DATA_W-1 -: PW_W]),
      .acc_bit (bus_wdata[0]),
      .wr_open (wr_open)
   );

   clkpol_engine u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .halt_wr (halt_wr),
      .ctl_wr  (ctl_wr),
      .wbits   (bus_wdata[2:0]),
      .halt_q  (halt_q),
      .ctl_q   (ctl_q)
   );

   clkpol_mask_bank #(
      .NUM_POL(NUM_POL), .NUM_CLK(NUM_CLK), .POL_W(POL_W), .RST_MASK(RST_MASK)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (mask_wr),
      .wr_idx    (m_idx),
      .wr_val    (bus_wdata[NUM_CLK-1:0]),
      .rd_idx    (m_idx),
      .pol_idx   (pol_sel),
      .rd_mask   (rd_mask),
      .sel_mask  (sel_mask),
      .mask_flat (mask_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_en <= RST_MASK;
      end else if (!halt_q) begin
         clk_en <= sel_mask;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (is_mask) begin
         bus_rdata = DATA_W'(rd_mask);
      end else begin
         case (bus_addr)
            ADDR_W'(REG_ACCESS): bus_rdata = DATA_W'(wr_open);
            ADDR_W'(REG_HALT):   bus_rdata = DATA_W'(halt_q);
            ADDR_W'(REG_CTL):    bus_rdata = DATA_W'(ctl_q);
            default:             bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/clkpol_sva.sv
module clkpol_sva #(
   parameter int unsigned NUM_POL = 4,
   parameter int unsigned NUM_CLK = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned PW_W    = 24,
   parameter logic [PW_W-1:0] PASSWD = 24'h5AC3E7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [PW_W-1:0]            wkey,
   input logic [2:0]                 wlow,
   input logic                       wr_open,
   input logic                       halt_q,
   input logic                       go_q,
   input logic [NUM_CLK-1:0]         sel_mask,
   input logic [NUM_POL*NUM_CLK-1:0] mask_flat,
   input logic [NUM_CLK-1:0]         clk_en
);
   p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && wkey != PASSWD) |=> $stable(wr_open));

   p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !wr_open && bus_addr != '0) |=> $stable(mask_flat));

   p_run_no_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_q) |=> $stable(mask_flat));

   p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_q) |=> (clk_en == $past(sel_mask)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> $stable(clk_en));

   p_go_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |=> (!go_q && !halt_q));

   p_go_bare_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wr_open && bus_addr == ADDR_W'(2) && wlow == 3'b001 && !go_q)
      |=> !go_q);
endmodule

bind clkpol_regs clkpol_sva #(
   .NUM_POL(NUM_POL), .NUM_CLK(NUM_CLK), .ADDR_W(ADDR_W),
   .PW_W(PW_W), .PASSWD(PASSWD)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .wkey      (bus_wdata[DATA_W-1 -: PW_W]),
   .wlow      (bus_wdata[2:0]),
   .wr_open   (wr_open),
   .halt_q    (halt_q),
   .go_q      (ctl_q.go),
   .sel_mask  (sel_mask),
   .mask_flat (mask_flat),
   .clk_en    (clk_en)
);

// File: tb/clkpol_regs_tb.sv
module clkpol_regs_tb;
   localparam logic [1:0] K_WR = 2'd0;
   localparam logic [1:0] K_RD = 2'd1;
   localparam logic [1:0] K_EN = 2'd2;
   localparam logic [31:0] OPEN  = 32'h5AC3E701;
   localparam logic [31:0] CLOSE = 32'h5AC3E700;

   typedef struct packed {
      logic [1:0]  kind;
      logic [2:0]  addr;
      logic [31:0] data;
      logic [1:0]  pol;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VEC [NV] = '{
      '{K_RD, 3'd0, 32'h0,        2'd0, 4'd1},   // R1 locked
      '{K_RD, 3'd4, 32'hFFFFFFFF, 2'd0, 4'd1},   // R1 mask reset
      '{K_RD, 3'd2, 32'h0,        2'd0, 4'd1},   // R1 ctl reset
      '{K_EN, 3'd0, 32'hFFFFFFFF, 2'd0, 4'd1},   // R1 enables
      '{K_WR, 3'd1, 32'h1,        2'd0, 4'd3},   // R3 locked halt write
      '{K_RD, 3'd1, 32'h0,        2'd0, 4'd3},
      '{K_WR, 3'd0, 32'h12345601, 2'd0, 4'd2},   // R2 bad password
      '{K_RD, 3'd0, 32'h0,        2'd0, 4'd2},
      '{K_WR, 3'd0, OPEN,         2'd0, 4'd2},   // R2 unlock
      '{K_RD, 3'd0, 32'h1,        2'd0, 4'd2},
      '{K_WR, 3'd4, 32'h000000F0, 2'd0, 4'd6},   // R6 write while running
      '{K_RD, 3'd4, 32'hFFFFFFFF, 2'd0, 4'd6},
      '{K_WR, 3'd1, 32'h1,        2'd0, 4'd5},   // R5 halt
      '{K_RD, 3'd1, 32'h1,        2'd0, 4'd5},
      '{K_WR, 3'd4, 32'h000000F0, 2'd0, 4'd6},
      '{K_WR, 3'd5, 32'h00000F00, 2'd0, 4'd6},
      '{K_WR, 3'd6, 32'hA5A5A5A5, 2'd0, 4'd6},
      '{K_WR, 3'd7, 32'h00000001, 2'd0, 4'd6},
      '{K_RD, 3'd4, 32'h000000F0, 2'd0, 4'd6},   // R6 accepted when halted
      '{K_RD, 3'd6, 32'hA5A5A5A5, 2'd0, 4'd6},
      '{K_EN, 3'd0, 32'hFFFFFFFF, 2'd0, 4'd8},   // R8 held
      '{K_EN, 3'd0, 32'hFFFFFFFF, 2'd2, 4'd8},
      '{K_WR, 3'd2, 32'h1,        2'd0, 4'd10},  // R10 bare GO
      '{K_RD, 3'd1, 32'h1,        2'd0, 4'd10},
      '{K_RD, 3'd2, 32'h0,        2'd0, 4'd10},
      '{K_WR, 3'd2, 32'h3,        2'd0, 4'd9},   // R9 GO + ATL
      '{K_RD, 3'd1, 32'h0,        2'd0, 4'd9},
      '{K_RD, 3'd2, 32'h2,        2'd0, 4'd9},
      '{K_EN, 3'd0, 32'h000000F0, 2'd0, 4'd7},   // R7 per policy
      '{K_EN, 3'd0, 32'h00000F00, 2'd1, 4'd7},
      '{K_EN, 3'd0, 32'hA5A5A5A5, 2'd2, 4'd7},
      '{K_EN, 3'd0, 32'h00000001, 2'd3, 4'd7},
      '{K_WR, 3'd0, CLOSE,        2'd0, 4'd4},   // R4 relock
      '{K_RD, 3'd0, 32'h0,        2'd0, 4'd4},
      '{K_WR, 3'd1, 32'h1,        2'd0, 4'd4},
      '{K_RD, 3'd1, 32'h0,        2'd0, 4'd4},
      '{K_RD, 3'd5, 32'h00000F00, 2'd0, 4'd11},  // R11 read while locked
      '{K_RD, 3'd3, 32'h0,        2'd0, 4'd11}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  pol_sel = '0;
   logic [31:0] clk_en;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   clkpol_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pol_sel(pol_sel),
      .clk_en(clk_en)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(req, bus_rdata, e);
   endtask

   task automatic en(input logic [1:0] p, input logic [31:0] e, input string req);
      @(negedge clk);
      pol_sel = p;
      repeat (2) @(negedge clk);
      check(req, clk_en, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[i].req);
         case (VEC[i].kind)
            K_WR:    wr(VEC[i].addr, VEC[i].data);
            K_RD:    rd(VEC[i].addr, VEC[i].data, tag);
            default: en(VEC[i].pol, VEC[i].data, tag);
         endcase
      end
      // R7 latency: new policy visible after exactly one edge
      @(negedge clk);
      pol_sel = 2'd1;
      #1;
      check("R7 before edge", clk_en, 32'h00000001);
      @(negedge clk);
      check("R7 one edge", clk_en, 32'h00000F00);
      // R9 restart via GO_AC after changing policy 1
      wr(3'd0, OPEN);
      wr(3'd1, 32'h1);
      wr(3'd5, 32'h0);
      check("R8 held during update", clk_en, 32'h00000F00);
      wr(3'd2, 32'h5);
      rd(3'd2, 32'h4, "R9 AC mode");
      en(2'd1, 32'h0, "R9 new mask live");
      // R1 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 enables after reset", clk_en, 32'hFFFFFFFF);
      rst_n = 1'b1;
      rd(3'd5, 32'hFFFFFFFF, "R1 mask after reset");
      rd(3'd0, 32'h0, "R1 relocked after reset");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule